// File: doc/BRIEF.md
# Locked read-modify-write bus master

This block is a bus-master sequencer for an asynchronous 32-bit bus that uses an acknowledge handshake. One start pulse launches an indivisible sequence. The block reads one operand, keeps the returned word, combines it with a user value, and writes the result back to the same location. A lock output stays high from the first bus state of the read to the last bus state of the write, so an arbiter or memory controller can keep other masters off the bus in between.

Each system clock cycle stands for one half-clock bus state (S0 to S5). Each transfer has the same shape:
- S0 sets up address, function code, size and direction.
- S1 raises the strobes.
- S2 samples the acknowledge.
- Wait states repeat while neither acknowledge line is recognized.
- S3 and S4 finish the transfer.
- S5 drops the strobes and holds until the responder releases both acknowledge lines.

Each acknowledge line passes through a synchronizer before it is recognized. The original read word is returned with a one-cycle done pulse. All bus control lines are active high.

Top module: `rmw_bus_master`

## Requirements
- R1: While reset is held, and after it is released with no start, these outputs are 0: lock, address strobe, data strobe, output enable, data-drive enable, done, address, function code, size and lanes. Read/write is 1.
- R2: In each transfer the lock (read) or the write direction (write) changes, with the address, function code and size valid, exactly one cycle before the address strobe rises. The address does not change while lock is high.
- R3: Acknowledge is recognized when either line is high, after a two-flop synchronizer. If the responder drives acknowledge D cycles after the strobe rises (D ≥ 0), the strobe stays high for exactly D+5 cycles.
- R4: Read data is latched at the end of S3 of the read. It appears on rd_value, unchanged, when done pulses.
- R5: The write uses the captured address, function code and size, with read/write low. Output enable is high only during the read strobe. Write data is driven with the data-drive enable from the first strobe cycle of the write.
- R6: The written word depends on the operation code: 00 gives the user value, 01 gives read OR value, 10 gives read AND value, 11 gives the user value.
- R7: Lock stays high with no gap from read S0 through write S5, and each sequence has exactly two strobe assertions (read, then write).
- R8: After the read strobe falls, the write strobe does not rise until both acknowledge lines are low. If the responder releases acknowledge H cycles after the strobe falls, the strobe stays low for exactly H+4 cycles.
- R9: Lane mask bit 3 is bits 31:24 (byte offset 0) and bit 0 is bits 7:0 (offset 3). The size code gives the byte count: 01 is one byte, 10 is two, 11 is three, 00 is four. The enabled lanes run from the offset in address bits 1:0 up to offset 3 at most.
- R10: A start during a sequence is ignored. Done is a one-cycle pulse, once per sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one cycle per half-clock bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a sequence (taken only when idle) |
| req_addr | input | 32 | Operand address |
| req_fc | input | 4 | Function code (address space) |
| req_siz | input | 2 | Operand size code |
| req_op | input | 2 | Modify operation code |
| req_val | input | 32 | Modify value |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rd_value | output | 32 | Word latched in the read |
| bus_addr | output | 32 | Bus address |
| bus_fc | output | 4 | Bus function code |
| bus_siz | output | 2 | Bus size code |
| bus_lanes | output | 4 | Active byte lanes |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_lock | output | 1 | Indivisible-sequence indicator |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_oe | output | 1 | Read output enable |
| bus_dout | output | 32 | Write data |
| bus_dout_en | output | 1 | Write data driven |
| bus_din | input | 32 | Read data |
| bus_dsack | input | 2 | Acknowledge lines |

## Verification
The assertions check these rules on every cycle:
- the strobe rises only after a cycle of lock or set-up;
- the strobe is always inside lock;
- the address holds while locked;
- direction never returns to read inside a locked sequence;
- output enable and data drive follow direction;
- the strobe falls only three cycles after a recognized acknowledge;
- the read latch captures the bus data;
- done lasts one cycle.

Only the bench scenarios can show the rest:
- the exact D+5 and H+4 timings against a responder with programmed delays;
- the modified write value for each operation code;
- the lane decoding at each offset;
- that a stray start is ignored.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  parameter int unsigned RMW_DW    = 32;
  parameter int unsigned RMW_LANES = RMW_DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_WAIT, ST_S3, ST_S4, ST_S5
  } rmw_state_e;

  // Modify step applied to the latched read word.
  function automatic logic [RMW_DW-1:0] apply_modify(
    input logic [1:0]        op,
    input logic [RMW_DW-1:0] rd,
    input logic [RMW_DW-1:0] val
  );
    case (op)
      2'b01:   return rd | val;
      2'b10:   return rd & val;
      default: return val;
    endcase
  endfunction

  // Lane mask, MSB = byte offset 0; size 00 means a full word.
  function automatic logic [RMW_LANES-1:0] lane_mask(
    input logic [1:0] siz,
    input logic [1:0] ofs
  );
    logic [2:0]           cnt;
    logic [RMW_LANES-1:0] m;
    cnt = (siz == 2'b00) ? 3'd4 : {1'b0, siz};
    m   = ~({RMW_LANES{1'b1}} >> cnt);
    return m >> ofs;
  endfunction

endpackage

// File: rtl/rmw_ack_sync.sv
module rmw_ack_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic             any_seen
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign any_seen = |stg[STAGES-1];
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_seen,
  output logic load_req,
  output logic rd_latch,
  output logic lock,
  output logic rw,
  output logic strobe,
  output logic oe,
  output logic dout_en,
  output logic done
);
  rmw_state_e st_q, st_d;
  logic       wr_q, wr_d;
  logic       done_d;

  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin st_d = ST_S0; wr_d = 1'b0; end
      ST_S0:   st_d = ST_S1;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ack_seen ? ST_S3 : ST_WAIT;
      ST_WAIT: st_d = ack_seen ? ST_S3 : ST_WAIT;
      ST_S3:   st_d = ST_S4;
      ST_S4:   st_d = ST_S5;
      ST_S5: begin
        if (!ack_seen) begin
          if (wr_q) begin
            st_d   = ST_IDLE;
            wr_d   = 1'b0;
            done_d = 1'b1;
          end else begin
            st_d = ST_S0;
            wr_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      wr_q <= wr_d;
      done <= done_d;
    end
  end

  assign load_req = (st_q == ST_IDLE) && start;
  assign rd_latch = (st_q == ST_S3) && !wr_q;
  assign lock     = (st_q != ST_IDLE);
  assign rw       = !wr_q;
  assign strobe   = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_WAIT) ||
                    (st_q == ST_S3) || (st_q == ST_S4);
  assign oe       = strobe && !wr_q;
  assign dout_en  = strobe && wr_q;
endmodule

// File: rtl/rmw_data.sv
module rmw_data
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FC_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_req,
  input  logic                 rd_latch,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [FC_W-1:0]      req_fc,
  input  logic [1:0]           req_siz,
  input  logic [1:0]           req_op,
  input  logic [RMW_DW-1:0]    req_val,
  input  logic [RMW_DW-1:0]    bus_din,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [FC_W-1:0]      fc_q,
  output logic [1:0]           siz_q,
  output logic [RMW_DW-1:0]    rd_q,
  output logic [RMW_DW-1:0]    wdata,
  output logic [RMW_LANES-1:0] lanes
);
  logic [1:0]        op_q;
  logic [RMW_DW-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      fc_q   <= '0;
      siz_q  <= '0;
      op_q   <= '0;
      val_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (load_req) begin
        addr_q <= req_addr;
        fc_q   <= req_fc;
        siz_q  <= req_siz;
        op_q   <= req_op;
        val_q  <= req_val;
      end
      if (rd_latch) rd_q <= bus_din;
    end
  end

  assign wdata = apply_modify(op_q, rd_q, val_q);
  assign lanes = lane_mask(siz_q, addr_q[1:0]);
endmodule

// File: rtl/rmw_bus_master.sv
module rmw_bus_master
  import rmw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FC_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [FC_W-1:0]      req_fc,
  input  logic [1:0]           req_siz,
  input  logic [1:0]           req_op,
  input  logic [RMW_DW-1:0]    req_val,
  output logic                 done,
  output logic [RMW_DW-1:0]    rd_value,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [FC_W-1:0]      bus_fc,
  output logic [1:0]           bus_siz,
  output logic [RMW_LANES-1:0] bus_lanes,
  output logic                 bus_rw,
  output logic                 bus_lock,
  output logic                 bus_as,
  output logic                 bus_ds,
  output logic                 bus_oe,
  output logic [RMW_DW-1:0]    bus_dout,
  output logic                 bus_dout_en,
  input  logic [RMW_DW-1:0]    bus_din,
  input  logic [1:0]           bus_dsack
);
  logic                 ack_seen, load_req, rd_latch, strobe;
  logic [ADDR_W-1:0]    addr_q;
  logic [FC_W-1:0]      fc_q;
  logic [1:0]           siz_q;
  logic [RMW_DW-1:0]    wdata;
  logic [RMW_LANES-1:0] lanes;

  rmw_ack_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bus_dsack), .any_seen(ack_seen)
  );

  rmw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ack_seen(ack_seen),
    .load_req(load_req), .rd_latch(rd_latch), .lock(bus_lock), .rw(bus_rw),
    .strobe(strobe), .oe(bus_oe), .dout_en(bus_dout_en), .done(done)
  );

  rmw_data #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .rd_latch(rd_latch),
    .req_addr(req_addr), .req_fc(req_fc), .req_siz(req_siz), .req_op(req_op),
    .req_val(req_val), .bus_din(bus_din), .addr_q(addr_q), .fc_q(fc_q),
    .siz_q(siz_q), .rd_q(rd_value), .wdata(wdata), .lanes(lanes)
  );

  assign bus_as    = strobe;
  assign bus_ds    = strobe;
  assign bus_addr  = bus_lock ? addr_q : '0;
  assign bus_fc    = bus_lock ? fc_q : '0;
  assign bus_siz   = bus_lock ? siz_q : '0;
  assign bus_lanes = bus_lock ? lanes : '0;
  assign bus_dout  = bus_dout_en ? wdata : '0;
endmodule

// File: rtl/rmw_bus_master_chk.sv
module rmw_bus_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [DW-1:0]     rd_value,
  input logic [DW-1:0]     bus_din,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rw,
  input logic              bus_lock,
  input logic              bus_as,
  input logic              bus_oe,
  input logic              bus_dout_en,
  input logic              ack_seen,
  input logic              rd_latch
);
  a_r1_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_lock && !bus_as));

  a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as) |-> ($past(bus_lock) && !$past(bus_as)));

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && $past(bus_lock)) |-> $stable(bus_addr));

  a_r3_strobe_end_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as) |-> $past(ack_seen, 3));

  a_r4_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> (rd_value == $past(bus_din)));

  a_r5_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_rw && bus_as));

  a_r5_drive_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> (!bus_rw && bus_as));

  a_r7_strobe_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> bus_lock);

  a_r7_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && $past(bus_lock)) |-> !$rose(bus_rw));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rmw_bus_master rmw_bus_master_chk #(.ADDR_W(ADDR_W), .DW(rmw_pkg::RMW_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rd_value(rd_value), .bus_din(bus_din),
  .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_lock(bus_lock), .bus_as(bus_as),
  .bus_oe(bus_oe), .bus_dout_en(bus_dout_en), .ack_seen(ack_seen),
  .rd_latch(rd_latch)
);

// File: tb/rmw_bus_master_tb.sv
module rmw_bus_master_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  fc;
    logic [1:0]  siz;
    logic [1:0]  op;
    logic [31:0] val;
    logic [31:0] rdin;
    logic [7:0]  dly;
    logic [7:0]  hold;
    logic [1:0]  ack;
    logic [31:0] wexp;
    logic [3:0]  lanes;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_1000, 4'h5, 2'b00, 2'b01, 32'h0000_00F0, 32'h1234_5600, 8'd0, 8'd0, 2'b11, 32'h1234_56F0, 4'b1111},
    '{32'h0000_2001, 4'h1, 2'b01, 2'b10, 32'hFF00_FF00, 32'hA5A5_A5A5, 8'd2, 8'd1, 2'b01, 32'hA500_A500, 4'b0100},
    '{32'h0000_3002, 4'h2, 2'b10, 2'b00, 32'hCAFE_BABE, 32'h0000_0001, 8'd1, 8'd3, 2'b10, 32'hCAFE_BABE, 4'b0011},
    '{32'h0000_4003, 4'h6, 2'b11, 2'b11, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 8'd4, 8'd0, 2'b01, 32'h0F0F_0F0F, 4'b0001},
    '{32'h8000_0001, 4'hD, 2'b11, 2'b01, 32'h8000_0001, 32'h0000_0100, 8'd0, 8'd2, 2'b10, 32'h8000_0101, 4'b0111},
    '{32'hFFFF_FFFE, 4'h7, 2'b01, 2'b10, 32'h0000_0000, 32'hDEAD_BEEF, 8'd3, 8'd0, 2'b11, 32'h0000_0000, 4'b0010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_fc = '0;
  logic [1:0]  req_siz = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_val = '0;
  logic        done;
  logic [31:0] rd_value;
  logic [31:0] bus_addr;
  logic [3:0]  bus_fc;
  logic [1:0]  bus_siz;
  logic [3:0]  bus_lanes;
  logic        bus_rw, bus_lock, bus_as, bus_ds, bus_oe, bus_dout_en;
  logic [31:0] bus_dout;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_dsack = '0;

  rmw_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr), .req_fc(req_fc),
    .req_siz(req_siz), .req_op(req_op), .req_val(req_val), .done(done),
    .rd_value(rd_value), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_siz(bus_siz),
    .bus_lanes(bus_lanes), .bus_rw(bus_rw), .bus_lock(bus_lock), .bus_as(bus_as),
    .bus_ds(bus_ds), .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .bus_dsack(bus_dsack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Responder settings
  int unsigned r_dly = 0, r_hold = 0;
  logic [1:0]  r_ack = 2'b11;
  logic [31:0] r_din = '0;
  int unsigned as_cnt = 0, rel_cnt = 0;

  // Monitor state
  int unsigned cyc = 0, setup_cyc = 0, fall_cyc = 0, as_run = 0;
  int unsigned n_rise = 0, n_done = 0, lock_gap = 0, overlap = 0, gap_w = 0;
  int unsigned setup_d [2];
  int unsigned as_len [2];
  bit          in_seq = 0;
  bit          p_lock = 0, p_rw = 1, p_as = 0;
  logic [31:0] rd_seen = '0, wr_addr = '0, wr_data = '0;
  logic [3:0]  wr_fc = '0, lanes_seen = '0;
  logic [1:0]  wr_siz = '0;
  logic        wr_den = 0, wr_oe = 0, rd_oe = 0;

  always @(negedge clk) begin
    cyc++;
    if (bus_lock && !p_lock) begin setup_cyc = cyc; in_seq = 1; end
    if (!bus_rw && p_rw) setup_cyc = cyc;
    if (in_seq && !bus_lock && !done) lock_gap++;
    if (bus_as && !p_as) begin
      n_rise++;
      if (bus_dsack != 2'b00) overlap++;
      if (n_rise <= 2) setup_d[n_rise-1] = cyc - setup_cyc;
      if (bus_rw) begin
        rd_oe = bus_oe;
        lanes_seen = bus_lanes;
      end else begin
        wr_addr = bus_addr; wr_fc = bus_fc; wr_siz = bus_siz;
        wr_data = bus_dout; wr_den = bus_dout_en; wr_oe = bus_oe;
        gap_w = cyc - fall_cyc;
      end
    end
    if (bus_as) as_run++;
    if (!bus_as && p_as) begin
      if (n_rise >= 1 && n_rise <= 2) as_len[n_rise-1] = as_run;
      as_run = 0;
      fall_cyc = cyc;
    end
    if (done) begin n_done++; rd_seen = rd_value; in_seq = 0; end
    p_lock = bus_lock; p_rw = bus_rw; p_as = bus_as;
    // Responder
    if (bus_as) begin
      rel_cnt = 0;
      if (as_cnt == r_dly) begin bus_dsack = r_ack; bus_din = r_din; end
      as_cnt++;
    end else begin
      as_cnt = 0;
      if (bus_dsack != 2'b00) begin
        if (rel_cnt == r_hold) begin bus_dsack = 2'b00; bus_din = '0; end
        else rel_cnt++;
      end
    end
  end

  task automatic run_one(input vec_t v, input bit extra_start);
    n_rise = 0; n_done = 0; lock_gap = 0; overlap = 0;
    setup_d[0] = 99; setup_d[1] = 99; as_len[0] = 0; as_len[1] = 0;
    r_dly = int'(v.dly); r_hold = int'(v.hold); r_ack = v.ack; r_din = v.rdin;
    @(negedge clk);
    start = 1'b1; req_addr = v.addr; req_fc = v.fc; req_siz = v.siz;
    req_op = v.op; req_val = v.val;
    @(negedge clk);
    start = 1'b0; req_addr = ~v.addr; req_fc = ~v.fc; req_val = ~v.val;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done == 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk("R2", "read setup cycles", setup_d[0], 1);
    chk("R2", "write setup cycles", setup_d[1], 1);
    chk("R3", "read strobe length", as_len[0], v.dly + 5);
    chk("R3", "write strobe length", as_len[1], v.dly + 5);
    chk("R4", "rd_value at done", rd_seen, v.rdin);
    chk("R5", "write address", wr_addr, v.addr);
    chk("R5", "write fc/siz", {26'd0, wr_fc, wr_siz}, {26'd0, v.fc, v.siz});
    chk("R5", "oe read/write, drive", {29'd0, rd_oe, wr_oe, wr_den}, 32'b101);
    chk("R6", "written word", wr_data, v.wexp);
    chk("R7", "lock gaps", lock_gap, 0);
    chk("R7", "strobe count", n_rise, 2);
    chk("R8", "strobe low gap", gap_w, v.hold + 4);
    chk("R8", "rise under ack", overlap, 0);
    chk("R9", "lanes", {28'd0, lanes_seen}, {28'd0, v.lanes});
    chk("R10", "done pulses", n_done, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "controls in reset",
        {26'd0, bus_lock, bus_as, bus_ds, bus_oe, bus_dout_en, done}, 32'd0);
    chk("R1", "rw in reset", {31'd0, bus_rw}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "controls after reset",
        {26'd0, bus_lock, bus_as, bus_ds, bus_oe, bus_dout_en, done}, 32'd0);
    chk("R1", "address after reset", bus_addr, 32'd0);
    chk("R1", "fc/siz/lanes after reset", {22'd0, bus_fc, bus_siz, bus_lanes}, 32'd0);

    for (int i = 0; i < NV; i++) run_one(TBL[i], 1'b0);

    // R10: stray start during a sequence
    run_one(TBL[2], 1'b1);
    chk("R10", "stray start address kept", wr_addr, TBL[2].addr);
    chk("R10", "idle after stray start", {31'd0, bus_lock}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule